// File: doc/BRIEF.md
# Coincident-Current Axis Line Selector

This block produces the digital drive enables for one axis of a coincident-current magnetic core array. It is built twice, once for the X axis and once for the Y axis. Each axis has 64 select lines. Every line runs between a near-end group and a far-end group. A line is addressed by switching on one source at one end and one sink at the other end. The direction of the half-select current depends on the operation. For a read, current flows from the near-end source to the far-end sink. For a write, it flows from the far-end source to the near-end sink, which is the opposite direction on the same wire.

The 6-bit line address is split into two 3-bit fields. The upper field picks one of eight near-end groups and the lower field picks one of eight far-end groups, so 16 source/sink pairs reach all 64 lines. The read enable of a group is the axis enable AND NOT write. The write enable is the axis enable AND write.

The address and mode are captured only while the axis enable is low, and they are frozen while it is high. A line therefore cannot be re-steered during a current pulse, and at most one source and one sink conduct at any time. The outputs are registered so that the drivers see clean, glitch-free levels.

Top module: `coinc_line_select`

## Requirements
- R1: While reset is asserted, all four drive vectors are zero.
- R2: On the clock edge after `axis_en` is sampled low, all four drive vectors are zero.
- R3: With the held mode read (`wr_mode`=0), an enabled cycle drives `src_near` bit A and `snk_far` bit B, and keeps `snk_near` and `src_far` at zero. Here A is `line_addr[5:3]` and B is `line_addr[2:0]`.
- R4: With the held mode write (`wr_mode`=1), an enabled cycle drives `src_far` bit B and `snk_near` bit A, and keeps `src_near` and `snk_far` at zero.
- R5: Whenever any output is active, exactly one source bit and exactly one sink bit are set across all four vectors.
- R6: `line_addr` is captured only on edges where `axis_en` is low. Address changes while enabled do not move the driven line.
- R7: `wr_mode` is captured only on edges where `axis_en` is low. Mode changes while enabled do not reverse the current.
- R8: The outputs turn on at the first clock edge that samples `axis_en` high. They use the address and mode captured at the last edge that sampled `axis_en` low.
- R9: Line index L = 8*A + B. Corner lines 0, 7, 56 and 63 each reach their own single group at each end.
- R10: The near end never has its source and its sink active together, and neither does the far end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| axis_en | input | 1 | Axis current enable |
| wr_mode | input | 1 | 1 = write direction, 0 = read direction |
| line_addr | input | 6 | Line address; [5:3] near group, [2:0] far group |
| src_near | output | 8 | One-hot near-end source enables (read) |
| snk_near | output | 8 | One-hot near-end sink enables (write) |
| src_far | output | 8 | One-hot far-end source enables (write) |
| snk_far | output | 8 | One-hot far-end sink enables (read) |

## Verification
The assertions assume that `axis_en` is held low throughout reset. The freeze properties compare the held address across edges where the enable is high, so they rely on that low level to start the run from a defined held state. The stimulus releases reset with the enable low. It always sets address and mode in a cycle with the enable low before it raises the enable. It changes `line_addr` and `wr_mode` in the middle of a pulse only on purpose, to show that the frozen state is kept. All inputs are driven on the falling edge, so they never move near the sampling edge.

// File: rtl/ccsel_pkg.sv
package ccsel_pkg;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } line_dir_e;

  function automatic line_dir_e dir_from_mode(input logic wr);
    return wr ? DIR_WRITE : DIR_READ;
  endfunction

  function automatic logic read_go(input logic en, input line_dir_e d);
    return en && (d == DIR_READ);
  endfunction

  function automatic logic write_go(input logic en, input line_dir_e d);
    return en && (d == DIR_WRITE);
  endfunction

endpackage

// File: rtl/ccsel_capture.sv
module ccsel_capture
  import ccsel_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q,
  output line_dir_e         dir_q
);

  // Capture window open only while the axis is idle
  logic window_open;
  assign window_open = !en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      dir_q  <= DIR_READ;
    end else if (window_open) begin
      addr_q <= addr_in;
      dir_q  <= dir_from_mode(wr_in);
    end
  end

endmodule

// File: rtl/ccsel_group_dec.sv
module ccsel_group_dec #(
  parameter int SEL_W = 3,
  localparam int N    = 1 << SEL_W
) (
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic [N-1:0]     hot
);

  for (genvar g = 0; g < N; g++) begin : g_grp
    assign hot[g] = en && (sel == SEL_W'(g));
  end

endmodule

// File: rtl/ccsel_end_drive.sv
module ccsel_end_drive #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_go,
  input  logic         snk_go,
  input  logic [N-1:0] grp,
  output logic [N-1:0] src_q,
  output logic [N-1:0] snk_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      snk_q <= '0;
    end else begin
      src_q <= src_go ? grp : '0;
      snk_q <= snk_go ? grp : '0;
    end
  end

endmodule

// File: rtl/coinc_line_select.sv
module coinc_line_select
  import ccsel_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int FAR_W  = ADDR_W / 2,
  localparam int NEAR_W = ADDR_W - FAR_W,
  localparam int NEAR_N = 1 << NEAR_W,
  localparam int FAR_N  = 1 << FAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              axis_en,
  input  logic              wr_mode,
  input  logic [ADDR_W-1:0] line_addr,
  output logic [NEAR_N-1:0] src_near,
  output logic [NEAR_N-1:0] snk_near,
  output logic [FAR_N-1:0]  src_far,
  output logic [FAR_N-1:0]  snk_far
);

  // Held line address and direction, exposed for the checker
  logic [ADDR_W-1:0] hold_addr;
  line_dir_e         hold_dir;

  ccsel_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (axis_en),
    .wr_in  (wr_mode),
    .addr_in(line_addr),
    .addr_q (hold_addr),
    .dir_q  (hold_dir)
  );

  logic [NEAR_W-1:0] near_sel;
  logic [FAR_W-1:0]  far_sel;
  assign near_sel = hold_addr[ADDR_W-1:FAR_W];
  assign far_sel  = hold_addr[FAR_W-1:0];

  logic [NEAR_N-1:0] near_grp;
  logic [FAR_N-1:0]  far_grp;

  ccsel_group_dec #(.SEL_W(NEAR_W)) u_near_dec (
    .en (axis_en),
    .sel(near_sel),
    .hot(near_grp)
  );

  ccsel_group_dec #(.SEL_W(FAR_W)) u_far_dec (
    .en (axis_en),
    .sel(far_sel),
    .hot(far_grp)
  );

  // Direction-qualified enables
  logic rd_go, wr_go;
  assign rd_go = read_go(axis_en, hold_dir);
  assign wr_go = write_go(axis_en, hold_dir);

  // Near end: source for read, sink for write
  ccsel_end_drive #(.N(NEAR_N)) u_near (
    .clk   (clk),
    .rst_n (rst_n),
    .src_go(rd_go),
    .snk_go(wr_go),
    .grp   (near_grp),
    .src_q (src_near),
    .snk_q (snk_near)
  );

  // Far end: source for write, sink for read
  ccsel_end_drive #(.N(FAR_N)) u_far (
    .clk   (clk),
    .rst_n (rst_n),
    .src_go(wr_go),
    .snk_go(rd_go),
    .grp   (far_grp),
    .src_q (src_far),
    .snk_q (snk_far)
  );

endmodule

// File: rtl/ccsel_checker.sv
module ccsel_checker
  import ccsel_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int NEAR_N = 8,
  parameter int FAR_N  = 8,
  localparam int FAR_W = ADDR_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              axis_en,
  input logic [ADDR_W-1:0] hold_addr,
  input line_dir_e         hold_dir,
  input logic [NEAR_N-1:0] src_near,
  input logic [NEAR_N-1:0] snk_near,
  input logic [FAR_N-1:0]  src_far,
  input logic [FAR_N-1:0]  snk_far
);

  logic any_on;
  assign any_on = |{src_near, snk_near, src_far, snk_far};

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !any_on || !rst_n);

  a_r2_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !axis_en |=> !any_on);

  a_r3_read_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_near) |-> ((|snk_far) && !(|src_far) && !(|snk_near)));

  a_r4_write_pairing: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_far) |-> ((|snk_near) && !(|src_near) && !(|snk_far)));

  a_r5_one_source: assert property (@(posedge clk) disable iff (!rst_n)
    any_on |-> ($countones({src_near, src_far}) == 1));

  a_r5_one_sink: assert property (@(posedge clk) disable iff (!rst_n)
    any_on |-> ($countones({snk_near, snk_far}) == 1));

  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    axis_en |=> $stable(hold_addr));

  a_r7_dir_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    axis_en |=> $stable(hold_dir));

  a_r8_turn_on: assert property (@(posedge clk) disable iff (!rst_n)
    axis_en |=> any_on);

  a_r9_far_index: assert property (@(posedge clk) disable iff (!rst_n)
    (|snk_far) |-> (snk_far == (FAR_N'(1) << $past(hold_addr[FAR_W-1:0]))));

  a_r10_near_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|src_near, |snk_near}));

  a_r10_far_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|src_far, |snk_far}));

endmodule

bind coinc_line_select ccsel_checker #(
  .ADDR_W(ADDR_W),
  .NEAR_N(NEAR_N),
  .FAR_N (FAR_N)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .axis_en  (axis_en),
  .hold_addr(hold_addr),
  .hold_dir (hold_dir),
  .src_near (src_near),
  .snk_near (snk_near),
  .src_far  (src_far),
  .snk_far  (snk_far)
);

// File: tb/tb_coinc_line_select.sv
`timescale 1ns/1ps
module tb_coinc_line_select;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       axis_en = 1'b0;
  logic       wr_mode = 1'b0;
  logic [5:0] line_addr = '0;
  logic [7:0] src_near, snk_near, src_far, snk_far;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  coinc_line_select dut (
    .clk(clk), .rst_n(rst_n), .axis_en(axis_en), .wr_mode(wr_mode),
    .line_addr(line_addr), .src_near(src_near), .snk_near(snk_near),
    .src_far(src_far), .snk_far(snk_far)
  );

  // Behavioural reference: held line number and direction, expected vectors
  int         m_line = 0;
  bit         m_wr = 0;
  logic [7:0] e_sn = '0, e_kn = '0, e_sf = '0, e_kf = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_line = 0; m_wr = 0;
      e_sn = '0; e_kn = '0; e_sf = '0; e_kf = '0;
    end else begin
      e_sn = '0; e_kn = '0; e_sf = '0; e_kf = '0;
      if (axis_en) begin
        if (m_wr) begin
          e_sf[m_line % 8] = 1'b1;
          e_kn[m_line / 8] = 1'b1;
        end else begin
          e_sn[m_line / 8] = 1'b1;
          e_kf[m_line % 8] = 1'b1;
        end
      end else begin
        m_line = int'(line_addr);
        m_wr = wr_mode;
      end
    end
  end

  task automatic tick(input string tag);
    @(negedge clk);
    n_checks++;
    if (src_near !== e_sn || snk_near !== e_kn || src_far !== e_sf || snk_far !== e_kf) begin
      n_fail++;
      $display("FAIL %s: got sn=%b kn=%b sf=%b kf=%b exp sn=%b kn=%b sf=%b kf=%b",
               tag, src_near, snk_near, src_far, snk_far, e_sn, e_kn, e_sf, e_kf);
    end
    n_checks++;
    if (|{src_near, snk_near, src_far, snk_far} &&
        ($countones({src_near, src_far}) != 1 || $countones({snk_near, snk_far}) != 1)) begin
      n_fail++;
      $display("FAIL R5: src=%b snk=%b exp one source and one sink",
               {src_near, src_far}, {snk_near, snk_far});
    end
  endtask

  // One current pulse; optional disturbance of address or mode mid-pulse
  task automatic pulse(input int line, input bit wr, input int len,
                       input bit bump_addr, input bit bump_mode, input string tag);
    line_addr = 6'(line);
    wr_mode = wr;
    tick("R2");
    axis_en = 1'b1;
    tick({"R8,", tag});
    for (int i = 0; i < len; i++) begin
      if (bump_addr) line_addr = 6'(line ^ (i + 13));
      if (bump_mode) wr_mode = ~wr;
      if (bump_addr) tick({"R6,", tag});
      else if (bump_mode) tick({"R7,", tag});
      else tick(tag);
    end
    axis_en = 1'b0;
    tick("R2");
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout exp finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick("R1");
    tick("R1");
    rst_n = 1'b1;
    tick("R2");
    tick("R2");
    pulse(0, 1'b0, 3, 0, 0, "R9,R3");
    pulse(63, 1'b0, 2, 0, 0, "R9,R3");
    pulse(7, 1'b1, 2, 0, 0, "R9,R4");
    pulse(56, 1'b1, 2, 0, 0, "R9,R4,R10");
    pulse(21, 1'b0, 4, 1, 0, "R3");
    pulse(42, 1'b1, 4, 0, 1, "R4");
    pulse(35, 1'b0, 3, 0, 1, "R3,R10");
    for (int l = 0; l < 64; l++) pulse(l, l[0] ^ l[3], 1, 0, 0, l[0] ^ l[3] ? "R4" : "R3");
    // back-to-back with no idle gap beyond the capture cycle
    pulse(9, 1'b1, 1, 1, 1, "R4");
    pulse(9, 1'b0, 1, 0, 0, "R3");
    rst_n = 1'b0;
    tick("R1");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule